// File: doc/BRIEF.md
# Ring Oscillator Phase Quantizer

This block converts the tap levels of an N-stage ring of delay cells, sampled on the system clock, into a phase code with 2N levels and a per-sample frequency word. Each cell is taken as a stage whose positive output follows its positive input after a delay. The single inversion of the ring sits at the wrap from the last tap back to the first stage. Under that model a settled ring always shows exactly one stage whose input and output disagree, and that stage is the one currently switching.

A detector compares every stage's input with its output and raises one of two flags for it, one for a rising edge and one for a falling edge. That gives 2N flags, of which exactly one is set for a legal tap pattern. An encoder turns the one-hot flags into a binary phase index. A modular differentiator then subtracts the previous index from the new one, modulo 2N. Because the ring is a free-running integrator of its control input, this difference is proportional to that input. The caller must keep the phase advance between two samples below one full ring cycle, or the difference aliases.

Tap patterns that are not one-hot after detection are rejected and flagged, and the stored phase is left unchanged. The tap inputs are assumed to be already synchronous to `clk`.

Top module: `ring_phase_quantizer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `phase_idx`, `freq_word`, `freq_valid` and `code_err` are all cleared to 0 at that edge.
- R2: The input of stage 0 is the inverse of `taps[N-1]`. The input of stage i (i>0) is `taps[i-1]`. The output of stage i is `taps[i]`. A rising flag is set when a stage's input is 1 and its output is 0. A falling flag is set when its input is 0 and its output is 1.
- R3: A rising flag of stage k gives phase index k, and a falling flag of stage k gives N+k. So a pattern with taps[0..k-1]=1 and the rest 0 maps to k (k=0..N), and a pattern with taps[0..k-1]=0 and the rest 1 maps to N+k (0<k<N). `phase_idx` never reaches 2N.
- R4: `phase_idx` takes a legal sample's index one clock edge after the edge at which `sample_en` is high.
- R5: For a legal sample that has a stored predecessor, `freq_word` = (new index − previous index) mod 2N, and `freq_valid` is high for exactly one cycle.
- R6: The first legal sample after reset only loads the phase. `freq_valid` stays 0 for it.
- R7: A sample whose detector output does not have exactly one flag set raises `code_err` for one cycle. For that sample `phase_idx` and `freq_word` keep their values and `freq_valid` is 0.
- R8: At an edge where `sample_en` is low, `phase_idx` and `freq_word` hold, and `freq_valid` and `code_err` are 0.
- R9: The difference wraps correctly across the 2N boundary (for N=15: 29 then 2 gives 3, and 2 then 0 gives 28).
- R10: After a rejected sample, the next legal sample is differenced against the last legal index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Take the current tap levels as a sample at this edge |
| taps | input | N | Sampled output level of each ring stage |
| phase_idx | output | ceil(log2(2N)) | Last legal quantized phase, 0 to 2N-1 |
| freq_word | output | ceil(log2(2N)) | Phase advance since the previous legal sample, mod 2N |
| freq_valid | output | 1 | `freq_word` was updated by this sample |
| code_err | output | 1 | The last sample had an illegal tap pattern |

## Verification
Several properties are checked on every cycle. The phase range is always kept. Error and valid are never high together. The phase holds across rejected and idle samples. Each valid `freq_word` closes the modular sum from the previous phase to the new one. The encoder's index always points at the set flag.

Some behaviours only the bench's scenarios can show. These are the exact mapping from tap patterns to indices, the suppressed first difference after reset, the wrapped differences at the 2N boundary, and the differencing across a rejected sample against the last legal phase.

// File: rtl/pq_pkg.sv
// Shared helpers for the ring phase quantizer.
// Assumes: level counts are at least 2.
package pq_pkg;
    // Width of an index that can address 'levels' distinct phase states.
    function automatic int unsigned pq_idx_width(input int unsigned levels);
        return (levels <= 2) ? 1 : $clog2(levels);
    endfunction
endpackage

// File: rtl/pq_transition_detect.sv
// Transition detector: flags the switching stage of the ring.
// Assumes: stage i output is taps[i], stage i input is taps[i-1],
// and stage 0 input is the inverted last tap (the ring's only inversion).
// Flag k<STAGES marks a rising edge of stage k; flag STAGES+k marks a falling one.
module pq_transition_detect #(
    parameter int unsigned STAGES = 15,
    localparam int unsigned LEVELS = 2 * STAGES
) (
    input  logic [STAGES-1:0] taps,
    output logic [LEVELS-1:0] flags
);
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic stg_in;
        // Stage input: wrap inversion for stage 0, previous tap otherwise.
        if (i == 0) begin : g_wrap
            assign stg_in = ~taps[STAGES-1];
        end else begin : g_chain
            assign stg_in = taps[i-1];
        end
        // Rising and falling flags from input/output disagreement.
        assign flags[i]          = stg_in & ~taps[i];
        assign flags[STAGES + i] = ~stg_in & taps[i];
    end
endmodule

// File: rtl/pq_onehot_enc.sv
// One-hot to binary encoder with a legality flag.
// Assumes: a legal input has exactly one bit set; otherwise the index is
// an OR of several positions and must be ignored by the caller.
module pq_onehot_enc #(
    parameter int unsigned LEVELS = 30,
    localparam int unsigned IDXW = pq_pkg::pq_idx_width(LEVELS)
) (
    input  logic [LEVELS-1:0] onehot,
    output logic [IDXW-1:0]   idx,
    output logic              legal
);
    // OR together the position numbers of all set bits.
    always_comb begin
        idx = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (onehot[k]) idx = idx | IDXW'(k);
        end
    end

    // Legal only with exactly one flag set.
    assign legal = ($countones(onehot) == 1);

    // Encoded index must point at the flag that is set (R3).
    always_comb begin
        if (legal) begin
            assert_enc_points_R3: assert (int'(idx) < LEVELS && onehot[idx]);
        end
    end
endmodule

// File: rtl/pq_mod_diff.sv
// Modular differentiator: (cur - prev) mod LEVELS.
// Assumes: both operands already lie in 0..LEVELS-1.
module pq_mod_diff #(
    parameter int unsigned LEVELS = 30,
    localparam int unsigned IDXW = pq_pkg::pq_idx_width(LEVELS)
) (
    input  logic [IDXW-1:0] cur,
    input  logic [IDXW-1:0] prev,
    output logic [IDXW-1:0] diff
);
    logic [IDXW:0] wide;
    // Subtract, adding one full cycle when the phase wrapped.
    always_comb begin
        if (cur >= prev) wide = {1'b0, cur} - {1'b0, prev};
        else             wide = {1'b0, cur} + (IDXW+1)'(LEVELS) - {1'b0, prev};
        diff = wide[IDXW-1:0];
    end
endmodule

// File: rtl/ring_phase_quantizer.sv
// Ring oscillator phase quantizer top.
// Detects the switching stage, encodes it to a phase index of 2*STAGES levels
// and differences successive legal indices modulo 2*STAGES.
// Assumes: taps are synchronous to clk; phase advance per sample < one cycle.
module ring_phase_quantizer import pq_pkg::*; #(
    parameter int unsigned STAGES = 15,
    localparam int unsigned LEVELS = 2 * STAGES,
    localparam int unsigned IDXW = pq_idx_width(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [STAGES-1:0] taps,
    output logic [IDXW-1:0]   phase_idx,
    output logic [IDXW-1:0]   freq_word,
    output logic              freq_valid,
    output logic              code_err
);
    logic [LEVELS-1:0] flags;
    logic [IDXW-1:0]   new_idx;
    logic              new_legal;
    logic [IDXW-1:0]   step;
    logic              have_prev;

    pq_transition_detect #(.STAGES(STAGES)) u_detect (
        .taps  (taps),
        .flags (flags)
    );

    pq_onehot_enc #(.LEVELS(LEVELS)) u_enc (
        .onehot (flags),
        .idx    (new_idx),
        .legal  (new_legal)
    );

    pq_mod_diff #(.LEVELS(LEVELS)) u_diff (
        .cur  (new_idx),
        .prev (phase_idx),
        .diff (step)
    );

    // Sample register: update phase, difference and status per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_idx  <= '0;
            freq_word  <= '0;
            freq_valid <= 1'b0;
            code_err   <= 1'b0;
            have_prev  <= 1'b0;
        end else begin
            freq_valid <= 1'b0;
            code_err   <= 1'b0;
            if (sample_en) begin
                if (new_legal) begin
                    phase_idx <= new_idx;
                    have_prev <= 1'b1;
                    if (have_prev) begin
                        freq_word  <= step;
                        freq_valid <= 1'b1;
                    end
                end else begin
                    code_err <= 1'b1;
                end
            end
        end
    end

    // Phase index stays inside the 2N levels (R3).
    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase_idx) < LEVELS);

    // A valid word closes the modular sum from old to new phase (R5).
    assert_diff_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        freq_valid |-> ((int'($past(phase_idx)) + int'(freq_word)) % LEVELS) == int'(phase_idx));

    // Rejected sample never produces a valid word (R7).
    assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> !freq_valid);

    // Rejected sample leaves the stored phase unchanged (R7).
    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> $stable(phase_idx));

    // Without a sample the outputs hold and the strobes stay low (R8).
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_en) |-> (!freq_valid && !code_err && $stable(phase_idx) && $stable(freq_word)));
endmodule

// File: tb/ring_phase_quantizer_bench.sv
`timescale 1ns/1ps
module ring_phase_quantizer_bench;
    localparam int N = 15;
    localparam int L = 2 * N;
    localparam int W = 5;
    localparam int NV = 11;

    // Vector table: target index (-1 = illegal pattern) and expected outputs.
    localparam int TV_IDX [NV] = '{ 3, 5, 14, 15, 20, -1, 29,  2, 2,  0, 29};
    localparam int TV_VAL [NV] = '{ 0, 1,  1,  1,  1,  0,  1,  1, 1,  1,  1};
    localparam int TV_FRQ [NV] = '{ 0, 2,  9,  1,  5,  5,  9,  3, 0, 28, 29};
    localparam int TV_PH  [NV] = '{ 3, 5, 14, 15, 20, 20, 29,  2, 2,  0, 29};
    localparam int TV_ERR [NV] = '{ 0, 0,  0,  0,  0,  1,  0,  0, 0,  0,  0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_en = 1'b0;
    logic [N-1:0] taps = '0;
    logic [W-1:0] phase_idx, freq_word;
    logic         freq_valid, code_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ring_phase_quantizer #(.STAGES(N)) u_ring_phase_quantizer (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .taps(taps),
        .phase_idx(phase_idx), .freq_word(freq_word),
        .freq_valid(freq_valid), .code_err(code_err)
    );

    // Tap pattern for a phase index, built from the R3 pattern rule.
    function automatic logic [N-1:0] pattern(input int idx);
        logic [N-1:0] p;
        for (int b = 0; b < N; b++) begin
            if (idx <= N) p[b] = (b < idx);
            else          p[b] = (b >= idx - N);
        end
        return p;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic take(input logic [N-1:0] p);
        @(negedge clk);
        taps = p;
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state (drive samples during reset, all must be ignored).
        sample_en = 1'b1;
        taps = pattern(7);
        repeat (3) @(negedge clk);
        check("R1", "phase_idx", int'(phase_idx), 0);
        check("R1", "freq_word", int'(freq_word), 0);
        check("R1", "freq_valid", int'(freq_valid), 0);
        check("R1", "code_err", int'(code_err), 0);
        sample_en = 1'b0;
        rst_n = 1'b1;

        // Table walk: R3/R4 mapping, R5 difference, R6 first sample, R7/R10 illegal, R9 wrap.
        for (int v = 0; v < NV; v++) begin
            take(TV_IDX[v] < 0 ? N'(15'b000000000000101) : pattern(TV_IDX[v]));
            check("R4", "phase_idx", int'(phase_idx), TV_PH[v]);
            check(v == 0 ? "R6" : "R5", "freq_valid", int'(freq_valid), TV_VAL[v]);
            check(v >= 7 ? "R9" : (v == 6 ? "R10" : "R5"), "freq_word", int'(freq_word), TV_FRQ[v]);
            check("R7", "code_err", int'(code_err), TV_ERR[v]);
        end

        // R8: idle edges hold everything and drop the strobes.
        taps = pattern(4);
        @(negedge clk);
        @(negedge clk);
        check("R8", "phase_idx", int'(phase_idx), 29);
        check("R8", "freq_word", int'(freq_word), 29);
        check("R8", "freq_valid", int'(freq_valid), 0);

        // R2/R3: every legal pattern maps to its index (all steps of one).
        for (int k = 0; k < L; k++) begin
            take(pattern(k));
            check("R3", "phase_idx", int'(phase_idx), k);
            if (k > 0) check("R2", "freq_word", int'(freq_word), 1);
        end

        // R7: all-but-Johnson pattern 1010.. also rejected, strobe one cycle.
        take(N'(15'b010101010101010));
        check("R7", "code_err", int'(code_err), 1);
        check("R7", "phase_idx", int'(phase_idx), 29);
        @(negedge clk);
        check("R7", "code_err pulse", int'(code_err), 0);

        // R6: after a fresh reset the first sample gives no difference.
        do_reset();
        take(pattern(10));
        check("R6", "freq_valid", int'(freq_valid), 0);
        check("R6", "phase_idx", int'(phase_idx), 10);
        take(pattern(12));
        check("R5", "freq_word", int'(freq_word), 2);
        check("R5", "freq_valid", int'(freq_valid), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule